// File: doc/BRIEF.md
# Two-Wire Debug Bus Master

This block drives one complete frame at a time on a two-wire programming and debug bus. The bus has a clock line, which the block always drives, and one bidirectional data line. A host hands over a frame request: an opcode that picks one of four frame kinds, a byte count, and write data. The block then produces the START strobe, the instruction bits, the address or length field, the data bits and the closing STOP strobe. It switches its data driver on and off as the frame requires and, in data frames, waits for the target to end its WAIT field. Read results and an error flag come back with a one-cycle done pulse. A separate request kind produces a long low pulse on the clock line that resets the target.

Every bit occupies one slot of `T_SET + T_LOW + T_HOLD` system clocks. The clock line is high for `T_SET` cycles while the new data bit settles, low for `T_LOW` cycles, and high for `T_HOLD` cycles. The data line is sampled on the last high cycle of the slot, so the sample point sits well after the rising edge. The request side follows valid/ready rules: a request is taken on a cycle where both `req_valid` and `req_ready` are high. While the bus is busy `req_ready` is low and the block applies no back-pressure beyond that. It holds no queue, so a request that is not taken is simply not seen. The response is a plain one-cycle flag with no ready.

Top module: `dbg2w_master`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. A request is taken when `req_valid` and `req_ready` are both high, and `busy` stays high until the cycle in which `rsp_done` pulses. Requests made while busy have no effect on the frame in progress or on its results.
- R2: Every frame starts with a START slot and ends with a STOP slot. The data driver is off (`bus_dq_oe` low) during both.
- R3: After START, two instruction slots carry `req_op` bit 0 and then bit 1, with the driver on. The opcode values are 0 for data read, 1 for data write, 2 for address read and 3 for address write.
- R4: Address frames carry an 8-bit address field, least significant bit first, then STOP. In an address write the driver is on and sends `req_wdata[7:0]`. In an address read the driver is off, the eight samples fill `rsp_rdata[7:0]`, and the upper bits are 0.
- R5: Data frames send two LENGTH slots carrying `req_len` LSB first, with the driver on. They then move `req_len`+1 bytes, least significant bit first.
- R6: In a data write the WAIT field follows the data bits. In a data read it comes before them, and the sampled bits fill `rsp_rdata` from bit 0 while the unused upper bits stay 0. The driver is off in WAIT slots. WAIT ends on the first slot that samples a 1.
- R7: If `WAIT_MAX` WAIT slots in a row all sample 0, the block moves straight to STOP and reports `rsp_err` = 1 with `rsp_rdata` = 0. A 1 sampled on slot `WAIT_MAX` still counts as success.
- R8: Each bit slot holds the clock high for `T_SET` cycles, low for `T_LOW` cycles and high for `T_HOLD` cycles. `bus_dq_in` is sampled on the last cycle of the slot, and `bus_dq_oe` and `bus_dq_out` change only at slot boundaries.
- R9: A request with `req_reset` high holds the clock low for `RST_LOW` cycles and then high for `RST_HIGH` cycles, with the driver off. It then pulses `rsp_done` with `rsp_err` = 0.
- R10: After reset, and whenever the block is idle, `bus_ck` is high, the driver is off, `busy` is low and `rsp_done` is low.
- R11: `bus_dq_out` is 0 whenever `bus_dq_oe` is low.
- R12: `rsp_done` lasts exactly one cycle. `rsp_rdata` and `rsp_err` hold their values from that cycle until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Frame request present |
| req_ready | output | 1 | Block can take a request |
| req_reset | input | 1 | Request is a target reset pulse instead of a frame |
| req_op | input | 2 | Frame kind (0 data read, 1 data write, 2 address read, 3 address write) |
| req_len | input | 2 | Byte count minus one for data frames |
| req_wdata | input | 32 | Address (bits 7:0) or write data, LSB sent first |
| busy | output | 1 | Frame or reset pulse in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, right-justified |
| rsp_err | output | 1 | WAIT timeout occurred |
| bus_ck | output | 1 | Bus clock line |
| bus_dq_in | input | 1 | Data line as seen at the pin |
| bus_dq_out | output | 1 | Data value driven when enabled |
| bus_dq_oe | output | 1 | Data driver enable |

## Verification
The assertions assume that request fields are stable whenever `req_valid` is high. They also assume that `bus_dq_in` holds one value through each slot, since the block samples only on a slot's last cycle. Both hold only if the timing parameters are at least one cycle each and `WAIT_MAX` is at least one. The bench changes its inputs only on falling clock edges, and it changes the target's data-line value only at slot boundaries that it computes from the same timing parameters. While a frame runs, it drives junk request values only when the block is busy, and it lowers `req_valid` before the done cycle so that nothing unplanned is taken.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;
  localparam int LEN_W     = 2;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 1 << LEN_W;
  localparam int DATA_W    = BYTE_W * MAX_BYTES;
  localparam int ADDR_W    = 8;
  localparam int IDX_W     = $clog2(DATA_W);

  typedef enum logic [1:0] {
    OP_DREAD  = 2'b00,
    OP_DWRITE = 2'b01,
    OP_AREAD  = 2'b10,
    OP_AWRITE = 2'b11
  } op_e;

  typedef enum logic [3:0] {
    FLD_IDLE, FLD_START, FLD_INS, FLD_ADDR, FLD_LEN,
    FLD_DATA, FLD_WAIT, FLD_STOP, FLD_RST
  } fld_e;
endpackage

// File: rtl/dbg2w_tick.sv
// Slot timer: one bit slot (set/low/hold) or one long reset slot (low/high).
module dbg2w_tick #(
  parameter int T_SET    = 8,
  parameter int T_LOW    = 20,
  parameter int T_HOLD   = 25,
  parameter int RST_LOW  = 4200,
  parameter int RST_HIGH = 440
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_mode,
  output logic ck,
  output logic slot_end
);
  localparam int BIT_SLOT = T_SET + T_LOW + T_HOLD;
  localparam int RST_SLOT = RST_LOW + RST_HIGH;
  localparam int MAX_SLOT = (BIT_SLOT > RST_SLOT) ? BIT_SLOT : RST_SLOT;
  localparam int CW       = $clog2(MAX_SLOT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lo_beg, lo_end, last;

  always_comb begin
    if (long_mode) begin
      lo_beg = '0;
      lo_end = CW'(RST_LOW);
      last   = CW'(RST_SLOT - 1);
    end else begin
      lo_beg = CW'(T_SET);
      lo_end = CW'(T_SET + T_LOW);
      last   = CW'(BIT_SLOT - 1);
    end
  end

  assign slot_end = run && (cnt == last);
  assign ck       = !(run && (cnt >= lo_beg) && (cnt < lo_end));

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (!run)      cnt <= '0;
    else if (slot_end)  cnt <= '0;
    else                cnt <= cnt + CW'(1);
  end

  // R8: every slot closes with the clock high, so sampling follows a rising edge
  p_slot_ends_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> ck);
endmodule

// File: rtl/dbg2w_seq.sv
// Frame sequencer: walks the fields of a frame one slot at a time.
module dbg2w_seq
  import dbg2w_pkg::*;
#(
  parameter int WAIT_MAX = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_reset,
  input  logic [1:0]        req_op,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              slot_end,
  input  logic              dq_in,
  output logic              run,
  output logic              long_mode,
  output logic              dq_oe,
  output logic              dq_out,
  output logic              busy,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam int WCW = $clog2(WAIT_MAX + 1);

  fld_e              fld;
  logic [1:0]        op_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic [IDX_W-1:0]  idx;
  logic [WCW-1:0]    wcnt;
  logic              err_q, done_q;

  logic is_read, is_addr, addr_last, data_last, bit_val;

  assign is_read   = (op_q == OP_DREAD) || (op_q == OP_AREAD);
  assign is_addr   = op_q[1];
  assign addr_last = (idx == IDX_W'(ADDR_W - 1));
  assign data_last = (idx == {len_q, 3'b111});

  assign busy      = (fld != FLD_IDLE);
  assign req_ready = !busy;
  assign run       = busy;
  assign long_mode = (fld == FLD_RST);

  always_comb begin
    dq_oe   = 1'b0;
    bit_val = 1'b0;
    case (fld)
      FLD_INS:  begin dq_oe = 1'b1;     bit_val = op_q[idx[0]];  end
      FLD_LEN:  begin dq_oe = 1'b1;     bit_val = len_q[idx[0]]; end
      FLD_ADDR: begin dq_oe = !is_read; bit_val = wd_q[idx];     end
      FLD_DATA: begin dq_oe = !is_read; bit_val = wd_q[idx];     end
      default:  begin dq_oe = 1'b0;     bit_val = 1'b0;          end
    endcase
  end
  assign dq_out = dq_oe & bit_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fld    <= FLD_IDLE;
      op_q   <= '0;
      len_q  <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      idx    <= '0;
      wcnt   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (fld == FLD_IDLE) begin
        if (req_valid) begin
          op_q  <= req_op;
          len_q <= req_len;
          wd_q  <= req_wdata;
          rd_q  <= '0;
          err_q <= 1'b0;
          idx   <= '0;
          wcnt  <= '0;
          fld   <= req_reset ? FLD_RST : FLD_START;
        end
      end else if (slot_end) begin
        idx <= idx + IDX_W'(1);
        case (fld)
          FLD_START: begin idx <= '0; fld <= FLD_INS; end
          FLD_INS: if (idx[0]) begin
            idx <= '0;
            fld <= is_addr ? FLD_ADDR : FLD_LEN;
          end
          FLD_ADDR: begin
            if (is_read) rd_q[idx] <= dq_in;
            if (addr_last) fld <= FLD_STOP;
          end
          FLD_LEN: if (idx[0]) begin
            idx <= '0;
            fld <= is_read ? FLD_WAIT : FLD_DATA;
          end
          FLD_DATA: begin
            if (is_read) rd_q[idx] <= dq_in;
            if (data_last) begin
              idx <= '0;
              fld <= is_read ? FLD_STOP : FLD_WAIT;
            end
          end
          FLD_WAIT: begin
            idx <= '0;
            if (dq_in) begin
              wcnt <= '0;
              fld  <= is_read ? FLD_DATA : FLD_STOP;
            end else if (wcnt == WCW'(WAIT_MAX - 1)) begin
              err_q <= 1'b1;
              rd_q  <= '0;
              fld   <= FLD_STOP;
            end else begin
              wcnt <= wcnt + WCW'(1);
            end
          end
          FLD_STOP, FLD_RST: begin
            fld    <= FLD_IDLE;
            done_q <= 1'b1;
          end
          default: fld <= FLD_IDLE;
        endcase
      end
    end
  end

  assign rsp_done  = done_q;
  assign rsp_rdata = rd_q;
  assign rsp_err   = err_q;

  // R8: driver state moves only where a slot has just ended
  p_oe_at_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dq_oe) |-> $past(slot_end));
  // R7: the WAIT counter never passes its limit
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt < WCW'(WAIT_MAX));
  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R1: a request seen while busy leaves the captured frame untouched
  p_ignore_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_end) |=> ($stable(op_q) && $stable(len_q) && $stable(wd_q)));
endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master
  import dbg2w_pkg::*;
#(
  parameter int T_SET    = 8,
  parameter int T_LOW    = 20,
  parameter int T_HOLD   = 25,
  parameter int RST_LOW  = 4200,
  parameter int RST_HIGH = 440,
  parameter int WAIT_MAX = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_reset,
  input  logic [1:0]  req_op,
  input  logic [1:0]  req_len,
  input  logic [31:0] req_wdata,
  output logic        busy,
  output logic        rsp_done,
  output logic [31:0] rsp_rdata,
  output logic        rsp_err,
  output logic        bus_ck,
  input  logic        bus_dq_in,
  output logic        bus_dq_out,
  output logic        bus_dq_oe
);
  logic run, long_mode, slot_end;

  dbg2w_tick #(
    .T_SET(T_SET), .T_LOW(T_LOW), .T_HOLD(T_HOLD),
    .RST_LOW(RST_LOW), .RST_HIGH(RST_HIGH)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .long_mode(long_mode),
    .ck(bus_ck), .slot_end(slot_end)
  );

  dbg2w_seq #(.WAIT_MAX(WAIT_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_reset(req_reset),
    .req_op(req_op), .req_len(req_len), .req_wdata(req_wdata),
    .slot_end(slot_end), .dq_in(bus_dq_in),
    .run(run), .long_mode(long_mode),
    .dq_oe(bus_dq_oe), .dq_out(bus_dq_out), .busy(busy),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  // R10: an idle bus leaves the clock line high
  p_idle_ck_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> bus_ck);
  // R2: completion follows a final slot with the driver off and the clock high
  p_stop_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(!bus_dq_oe) && $past(bus_ck)));
  // R1: busy ends only together with the done pulse
  p_busy_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_done);
endmodule

// File: tb/sim_dbg2w_master.sv
`timescale 1ns/1ps
module sim_dbg2w_master;
  localparam int TS = 1, TL = 2, TH = 2, RL = 8, RH = 4, WM = 6;
  localparam int SLOT = TS + TL + TH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_reset = 1'b0, bus_dq_in = 1'b0;
  logic [1:0] req_op = '0, req_len = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, busy, rsp_done, rsp_err, bus_ck, bus_dq_out, bus_dq_oe;
  logic [31:0] rsp_rdata;

  int n_chk = 0, n_fail = 0;
  bit q_ck[$], q_oe[$], q_dq[$], q_tin[$];

  always #2.5 clk = ~clk;

  dbg2w_master #(.T_SET(TS), .T_LOW(TL), .T_HOLD(TH),
                 .RST_LOW(RL), .RST_HIGH(RH), .WAIT_MAX(WM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reset(req_reset), .req_op(req_op), .req_len(req_len),
    .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_ck(bus_ck),
    .bus_dq_in(bus_dq_in), .bus_dq_out(bus_dq_out), .bus_dq_oe(bus_dq_oe));

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_cyc(bit ck, bit oe, bit dq, bit tin);
    q_ck.push_back(ck); q_oe.push_back(oe); q_dq.push_back(dq); q_tin.push_back(tin);
  endtask

  // One bit slot of the reference model (R8 timing)
  task automatic put_slot(bit oe, bit dq, bit tin);
    for (int c = 0; c < SLOT; c++)
      put_cyc(!(c >= TS && c < TS + TL), oe, oe & dq, tin);
  endtask

  task automatic put_wait(int nz);
    if (nz >= WM) for (int i = 0; i < WM; i++) put_slot(0, 0, 0);
    else begin
      for (int i = 0; i < nz; i++) put_slot(0, 0, 0);
      put_slot(0, 0, 1);
    end
  endtask

  task automatic build(bit rs, bit [1:0] op, bit [1:0] len, bit [31:0] wd,
                       int nz, bit [31:0] td);
    int nb;
    q_ck.delete(); q_oe.delete(); q_dq.delete(); q_tin.delete();
    nb = 8 * (len + 1);
    if (rs) begin
      for (int i = 0; i < RL; i++) put_cyc(0, 0, 0, 0);
      for (int i = 0; i < RH; i++) put_cyc(1, 0, 0, 0);
      return;
    end
    put_slot(0, 0, 0);
    for (int i = 0; i < 2; i++) put_slot(1, op[i], 0);
    if (op[1]) begin
      for (int i = 0; i < 8; i++)
        if (op == 2'd3) put_slot(1, wd[i], 0); else put_slot(0, 0, td[i]);
    end else begin
      for (int i = 0; i < 2; i++) put_slot(1, len[i], 0);
      if (op == 2'd1) begin
        for (int i = 0; i < nb; i++) put_slot(1, wd[i], 0);
        put_wait(nz);
      end else begin
        put_wait(nz);
        if (nz < WM) for (int i = 0; i < nb; i++) put_slot(0, 0, td[i]);
      end
    end
    put_slot(0, 0, 0);
  endtask

  task automatic run(string tag, bit rs, bit [1:0] op, bit [1:0] len,
                     bit [31:0] wd, int nz, bit [31:0] td, bit junk);
    bit [31:0] exp_rd;
    bit exp_err;
    int n;
    exp_err = !rs && !op[1] && (nz >= WM);
    exp_rd  = '0;
    if (!rs && op == 2'd2) exp_rd = {24'h0, td[7:0]};
    if (!rs && op == 2'd0 && !exp_err)
      exp_rd = (len == 2'd3) ? td : (td & ((32'h1 << (8 * (len + 1))) - 1));
    build(rs, op, len, wd, nz, td);
    @(negedge clk);
    // R10: idle level between frames
    chk(bus_ck && !bus_dq_oe && req_ready && !rsp_done, "R10", "idle bus", bus_ck, 1);
    req_valid = 1; req_reset = rs; req_op = op; req_len = len; req_wdata = wd;
    @(negedge clk);
    if (junk) begin
      // R1: conflicting request held while busy must be ignored
      req_reset = !rs; req_op = ~op; req_len = ~len; req_wdata = ~wd;
    end else req_valid = 0;
    n = q_ck.size();
    for (int i = 0; i < n; i++) begin
      chk(bus_ck == q_ck[i], tag, $sformatf("R8 ck cycle %0d", i), bus_ck, q_ck[i]);
      chk(bus_dq_oe == q_oe[i], tag, $sformatf("R2 oe cycle %0d", i), bus_dq_oe, q_oe[i]);
      chk(bus_dq_out == q_dq[i], tag, $sformatf("R11 dq cycle %0d", i), bus_dq_out, q_dq[i]);
      chk(busy && !req_ready, "R1", $sformatf("busy cycle %0d", i), busy, 1);
      bus_dq_in = q_tin[i];
      if (i == n - 1) req_valid = 0;
      @(negedge clk);
    end
    bus_dq_in = 0;
    chk(rsp_done && !busy, "R1", {tag, " done cycle"}, rsp_done, 1);
    chk(rsp_err == exp_err, tag, "error flag", rsp_err, exp_err);
    chk(rsp_rdata == exp_rd, tag, "read data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk(!rsp_done, "R12", "done width", rsp_done, 0);
    chk(rsp_rdata == exp_rd && rsp_err == exp_err, "R12", "result held", rsp_rdata, exp_rd);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(bus_ck && !bus_dq_oe && !bus_dq_out && !busy && !rsp_done, "R10",
        "in reset", {bus_ck, bus_dq_oe, busy, rsp_done}, 4'b1000);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy && bus_ck, "R10", "after reset", req_ready, 1);
    run("R3 R4 aw",  0, 2'd3, 2'd0, 32'h0000_00A5, 0, 32'h0, 0);
    run("R4 ar",     0, 2'd2, 2'd0, 32'h0,         0, 32'hFFFF_FF3C, 0);
    run("R5 dw1",    0, 2'd1, 2'd0, 32'h0000_005A, 0, 32'h0, 0);
    run("R6 dw4",    0, 2'd1, 2'd3, 32'h1234_5678, 3, 32'h0, 0);
    run("R6 dr2",    0, 2'd0, 2'd1, 32'h0,         2, 32'hAAAA_BEEF, 0);
    run("R6 dr3 edge", 0, 2'd0, 2'd2, 32'h0,     WM - 1, 32'h7755_C3A1, 0);
    run("R7 dw to",  0, 2'd1, 2'd0, 32'h0000_00FF, WM, 32'h0, 0);
    run("R7 dr to",  0, 2'd0, 2'd3, 32'h0,        WM, 32'hFFFF_FFFF, 0);
    run("R9 reset",  1, 2'd0, 2'd0, 32'h0,        0, 32'h0, 0);
    run("R1 busy dw", 0, 2'd1, 2'd1, 32'h0000_C35A, 1, 32'h0, 1);
    run("R1 busy ar", 0, 2'd2, 2'd0, 32'h0,        0, 32'h0000_0081, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule